// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scanner

This block drives a bank of four common-anode seven-segment digits that share one segment bus. Four decimal digit values come in on separate ports. A free-running prescale counter picks one position at a time. The block decodes the picked digit to a segment pattern and pulls only that position's anode low. Because the scan runs fast enough, the eye sees all four digits lit at once.

The scan position is the two most significant bits of the prescale counter. The counter wraps on overflow, so no terminal-count compare or reload is needed. Each position is held for 2^(W-2) clocks. The anode and segment outputs leave the block from one shared register stage. A reset clears the counter and blanks the display.

Top module: `seg_scan_top`

## Requirements
- R1: Digit input 0 appears at the rightmost position, enabled by anode bit 0. Digit input 3 appears at the leftmost position, enabled by anode bit 3.
- R2: Anodes are active-low: a 0 on an anode bit lights that position.
- R3: Outside reset, exactly one of the four anode bits is low in every cycle after the first clock edge following reset release.
- R4: The scan position equals the top two bits of a W-bit counter that counts up by one each clock and wraps from all-ones to zero. The positions run in the order 0,1,2,3,0. The first position after reset is 0.
- R5: Each position stays selected for exactly 2^(W-2) consecutive cycles (64 when W = 8).
- R6: Reset is synchronous. While it is sampled high, all anodes are high and all segments are high, which blanks the display. It also clears the counter, so the scan restarts at position 0.
- R7: The anode pattern and the segment pattern are registered together. A segment value always belongs to the digit whose anode is low in that same cycle. It is the value that digit input held on the clock edge that loaded the output.
- R8: Segments are active-low with bit 6 = g down to bit 0 = a. The patterns for digits 0..9 are 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00 and 0x10.
- R9: A digit input of 10 to 15 gives all segments high (0x7F), so that position is dark.
- R10: After reset release, each output change takes effect one clock edge later. The first edge gives anodes 4'b1110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dig0_i | input | 4 | Digit for the rightmost position |
| dig1_i | input | 4 | Digit for the second position from the right |
| dig2_i | input | 4 | Digit for the second position from the left |
| dig3_i | input | 4 | Digit for the leftmost position |
| anode_n_o | output | 4 | Active-low anode enables, bit 0 = rightmost |
| seg_n_o | output | 7 | Active-low segments, bit 6 = g, bit 0 = a |

## Verification
A change of a digit input and a scan advance can land on the same clock edge. The risk is that a mismatched anode/segment pair slips out for one cycle. The bench provokes this by writing new values into the outgoing and incoming digits exactly on the edge where the position steps. It then requires that the very next output shows the new anode together with the new value of the incoming digit. A mid-scan reset is also pitted against a running scan, and the bench judges whether the display blanks and restarts at position 0.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int unsigned NUM_POS = 4;
  localparam int unsigned POS_W   = 2;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned DIG_W   = 4;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [POS_W-1:0] pos_t;

  localparam seg_t SEG_DARK = '1;

  // Active-low segment pattern, bit 6 = g .. bit 0 = a.
  function automatic seg_t digit_to_seg_n(input digit_t d);
    seg_t lit;
    case (d)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
    return ~lit;
  endfunction

  // Active-low anode enable for one position.
  function automatic logic [NUM_POS-1:0] pos_to_anode_n(input pos_t p);
    logic [NUM_POS-1:0] hot;
    hot = '0;
    hot[p] = 1'b1;
    return ~hot;
  endfunction

endpackage

// File: rtl/seg_scan_prescaler.sv
module seg_scan_prescaler
  import seg_scan_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  output pos_t pos_o,
  output logic step_o
);

  localparam int unsigned LOW_W = CNT_W - POS_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign pos_o  = cnt_q[CNT_W-1 -: POS_W];
  // Last cycle of the current dwell: the position moves on the next edge.
  assign step_o = &cnt_q[LOW_W-1:0];

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (&cnt_q) |=> (cnt_q == '0));

  // R5
  dwell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_o |=> $stable(pos_o));

  // R4
  pos_order_chk: assert property (@(posedge clk) disable iff (rst)
    step_o |=> (pos_o == pos_t'($past(pos_o) + 1'b1)));

endmodule

// File: rtl/seg_scan_select.sv
module seg_scan_select
  import seg_scan_pkg::*;
(
  input  digit_t dig_i [NUM_POS],
  input  pos_t   pos_i,
  output digit_t dig_o
);

  digit_t masked [NUM_POS];

  for (genvar g = 0; g < NUM_POS; g++) begin : g_lane
    assign masked[g] = (pos_i == pos_t'(g)) ? dig_i[g] : '0;
  end

  always_comb begin
    dig_o = '0;
    for (int k = 0; k < NUM_POS; k++) dig_o = dig_o | masked[k];
  end

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] dig0_i,
  input  logic [3:0] dig1_i,
  input  logic [3:0] dig2_i,
  input  logic [3:0] dig3_i,
  output logic [3:0] anode_n_o,
  output logic [6:0] seg_n_o
);

  pos_t   scan_pos;
  logic   scan_step;
  digit_t dig_arr [NUM_POS];
  digit_t cur_dig;
  seg_t   cur_seg;
  logic   live_q;
  logic [NUM_POS-1:0] anode_q;
  seg_t   seg_q;

  assign dig_arr[0] = dig0_i;
  assign dig_arr[1] = dig1_i;
  assign dig_arr[2] = dig2_i;
  assign dig_arr[3] = dig3_i;

  seg_scan_prescaler #(.CNT_W(CNT_W)) presc_i (
    .clk    (clk),
    .rst    (rst),
    .pos_o  (scan_pos),
    .step_o (scan_step)
  );

  seg_scan_select sel_i (
    .dig_i (dig_arr),
    .pos_i (scan_pos),
    .dig_o (cur_dig)
  );

  assign cur_seg = digit_to_seg_n(cur_dig);

  always_ff @(posedge clk) begin
    if (rst) begin
      anode_q <= '1;
      seg_q   <= SEG_DARK;
      live_q  <= 1'b0;
    end else begin
      anode_q <= pos_to_anode_n(scan_pos);
      seg_q   <= cur_seg;
      live_q  <= 1'b1;
    end
  end

  assign anode_n_o = anode_q;
  assign seg_n_o   = seg_q;

  // R3
  one_anode_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ($countones(~anode_n_o) == 1));

  // R6
  blank_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> (anode_n_o == 4'hF && seg_n_o == SEG_DARK));

  // R10
  first_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !live_q |=> (anode_n_o == 4'b1110));

endmodule

// File: tb/seg_scan_top_tb_top.sv
module seg_scan_top_tb_top;

  localparam int W     = 8;
  localparam int DWELL = 1 << (W - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] d [4];
  logic [3:0] anode_n;
  logic [6:0] seg_n;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  seg_scan_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst),
    .dig0_i(d[0]), .dig1_i(d[1]), .dig2_i(d[2]), .dig3_i(d[3]),
    .anode_n_o(anode_n), .seg_n_o(seg_n)
  );

  function automatic logic [6:0] pat(input logic [3:0] v);
    case (v)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; 9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  // Reference scan state from the requirements (R4, R6, R7, R10).
  int m_cnt = 0;
  logic [3:0] exp_an = 4'hF;
  logic [6:0] exp_seg = 7'h7F;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_cnt <= 0; exp_an <= 4'hF; exp_seg <= 7'h7F;
    end else begin
      int p;
      p = (m_cnt / DWELL) % 4;
      exp_an  <= ~(4'b0001 << p);
      exp_seg <= pat(d[p]);
      m_cnt   <= (m_cnt + 1) % (4 * DWELL);
    end
  end

  task automatic check(input string req, input logic [3:0] an_e, input logic [6:0] seg_e);
    tests++;
    if (anode_n !== an_e || seg_n !== seg_e) begin
      fails++;
      $display("FAIL %s: anode=%b seg=%h expected anode=%b seg=%h", req, anode_n, seg_n, an_e, seg_e);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compare against the reference every cycle; one check per call.
  task automatic track(input string req, input int n);
    int bad = 0;
    logic [3:0] ba; logic [6:0] bs; logic [3:0] ea; logic [6:0] es;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (anode_n !== exp_an || seg_n !== exp_seg) begin
        if (bad == 0) begin ba = anode_n; bs = seg_n; ea = exp_an; es = exp_seg; end
        bad++;
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d mismatching cycles, first anode=%b seg=%h expected anode=%b seg=%h",
               req, bad, ba, bs, ea, es);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    check("R6 reset blank", 4'hF, 7'h7F);
  endtask

  task automatic t_first;
    d[0] = 4'd1; d[1] = 4'd2; d[2] = 4'd3; d[3] = 4'd4;
    rst = 1'b0;
    tick(1);
    check("R10 R1 R2 first edge", 4'b1110, pat(4'd1));
  endtask

  task automatic t_order;
    // positions after DWELL, 2*DWELL, 3*DWELL more cycles; then wrap
    tick(DWELL);
    check("R4 R1 position 1", 4'b1101, pat(4'd2));
    tick(DWELL);
    check("R4 position 2", 4'b1011, pat(4'd3));
    tick(DWELL);
    check("R4 R1 position 3 leftmost", 4'b0111, pat(4'd4));
    tick(DWELL);
    check("R4 wrap to position 0", 4'b1110, pat(4'd1));
  endtask

  task automatic t_dwell;
    logic [3:0] start;
    int run = 0;
    // align to start of a dwell
    while (anode_n == exp_an && m_cnt % DWELL != 1) @(negedge clk);
    start = anode_n;
    while (anode_n == start) begin run++; @(negedge clk); end
    tests++;
    if (run != DWELL) begin
      fails++;
      $display("FAIL R5 dwell: actual=%0d expected=%0d", run, DWELL);
    end
  endtask

  task automatic t_track_scan;
    d[0] = 4'd7; d[1] = 4'd0; d[2] = 4'd9; d[3] = 4'd5;
    track("R3 R7 full scan", 4 * DWELL + 5);
  endtask

  task automatic t_codes;
    for (int v = 0; v < 10; v++) begin
      for (int k = 0; k < 4; k++) d[k] = 4'(v);
      tick(1);
      check("R8 decode", anode_n, pat(4'(v)));
      if ($countones(~anode_n) != 1) check("R3 one anode", 4'b1110, pat(4'(v)));
    end
  endtask

  task automatic t_invalid;
    for (int k = 0; k < 4; k++) d[k] = 4'd12;
    tick(2);
    check("R9 invalid dark", exp_an, 7'h7F);
    d[0] = 4'd15; d[1] = 4'd10; d[2] = 4'd11; d[3] = 4'd13;
    track("R9 invalid over scan", 4 * DWELL);
  endtask

  task automatic t_collide;
    logic [3:0] an_now;
    int p;
    d[0] = 4'd1; d[1] = 4'd2; d[2] = 4'd3; d[3] = 4'd4;
    // wait until the design's counter sits at the first cycle of a new dwell
    while (m_cnt % DWELL != 0) @(negedge clk);
    p = (m_cnt / DWELL) % 4;
    an_now = anode_n;
    d[p] = 4'd8; d[(p + 3) % 4] = 4'd6;
    tick(1);
    check("R7 change on scan step", ~(4'b0001 << p), pat(4'd8));
    if (an_now == anode_n) check("R7 anode moved", ~(4'b0001 << ((p + 3) % 4)), 7'h7F);
    track("R7 after collision", 2 * DWELL);
  endtask

  task automatic t_mid_reset;
    tick(DWELL + 7);
    rst = 1'b1;
    tick(1);
    check("R6 mid-scan reset blank", 4'hF, 7'h7F);
    rst = 1'b0;
    tick(1);
    check("R6 restart at position 0", 4'b1110, pat(d[0]));
    track("R6 R4 scan after reset", 2 * DWELL);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) d[k] = 4'd0;
    tick(1);
    t_reset();
    t_first();
    t_order();
    t_dwell();
    t_track_scan();
    t_codes();
    t_invalid();
    t_collide();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=under 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule